// File: doc/BRIEF.md
# Boot Condition Decision Sequencer

This block runs once after every reset and decides where the processor starts. It looks at a 32-bit boot security vector word and at a latched reset-cause byte. If needed it also listens on a serial receive line for a short, fixed window. The result is either a start address for the application or a request to enter the serial bootloader.

The conditions are tried in a fixed order. A security vector that lies inside the allowed address range wins, and is used at once as the start address. If the vector is not valid and the reset did not come from the external init pin, the default application entry is used. Only an init-pin reset opens the serial window. The window uses 2400 baud, 8 data bits, no parity and 1 stop bit, and lasts about 100 ms. The sync character 'V' selects the bootloader. Silence or any other traffic until the window closes selects the default entry.

The baud divider and the window length are derived from a system clock frequency parameter. The receiver oversamples each bit 16 times and takes its decision at the middle of the bit.

Top module: `boot_decider`

## Requirements
- R1: A boot vector word from 0x0004_0000 up to 0x0013_FFFF, both limits included, gives a done pulse in the first cycle after the first clock edge that follows reset release, with boot_mode=0 and start_addr equal to that word. This holds whatever the reset cause is.
- R2: A vector outside that range, including the erased value 0xFFFF_FFFF, together with a reset cause other than 0x80, gives the done pulse in the same cycle as R1, with boot_mode=0 and start_addr=0x000F_4000.
- R3: A vector outside the range together with a reset cause of exactly 0x80 raises rx_en in that same cycle instead of done. rx_en stays high for the whole listening window.
- R4: Serial frames are 8N1 at BAUD. The line idles high, the start bit is low, data is sent LSB first, and the stop bit is high. A correct frame carrying 0x56 gives a done pulse during that frame's stop bit, with boot_mode=1 and start_addr=0.
- R5: If the window ends with no sync byte, done rises exactly TIMEOUT_CYC+1 clock edges after reset release, with boot_mode=0 and start_addr=0x000F_4000. rx_en falls in that same cycle.
- R6: A byte other than 0x56, or a frame whose stop bit is low, is dropped. Listening continues until the window ends.
- R7: A low pulse on the line shorter than half a bit time is not treated as a start bit. The receiver goes back to idle and will still accept a later frame.
- R8: During reset, done, rx_en, boot_mode and start_addr are all 0. done is high for exactly one cycle. After it, boot_mode and start_addr stay unchanged until the next reset, and every reset starts a new decision.
- R9: The oversample divider is CLK_HZ/(BAUD*16) clocks and the window is CLK_HZ/1000*WINDOW_MS clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_vec | input | 32 | Boot security vector word |
| rst_cause | input | 8 | Latched reset-cause byte |
| rxd | input | 1 | Serial receive line, idle high |
| rx_en | output | 1 | High while the serial window is open |
| done | output | 1 | One-cycle pulse: the decision is ready |
| boot_mode | output | 1 | 1 = enter the bootloader, 0 = start the application |
| start_addr | output | 32 | Application start address, 0 in bootloader mode |

## Verification
The vector and reset-cause decisions are due in the cycle after the first clock edge that follows reset release. The bench checks that cycle exactly and requires done to stay low in every other cycle. A timeout is due exactly TIMEOUT_CYC+1 edges after release, and that edge is also checked exactly. A sync-byte result depends on the phase of the oversampling tick and on the two-stage input synchronizer. For that reason the bench accepts it only inside the stop-bit interval of the frame that carries it, and treats a pulse at any other time as a failure. After every done pulse the bench compares the held outputs cycle by cycle for a stretch of cycles.

// File: rtl/boot_decider.sv
module boot_decider #(
  parameter int CLK_HZ = 125_000_000,
  parameter int BAUD = 2400,
  parameter int WINDOW_MS = 100,
  parameter logic [31:0] VEC_LO = 32'h0004_0000,
  parameter logic [31:0] VEC_HI = 32'h0013_FFFF,
  parameter logic [31:0] DEF_ENTRY = 32'h000F_4000,
  parameter logic [7:0] INIT_CAUSE = 8'h80,
  parameter logic [7:0] SYNC_BYTE = 8'h56
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] boot_vec,
  input  logic [7:0]  rst_cause,
  input  logic        rxd,
  output logic        rx_en,
  output logic        done,
  output logic        boot_mode,
  output logic [31:0] start_addr
);
  localparam int OSR_DIV = CLK_HZ / (BAUD * 16);
  localparam int TIMEOUT_CYC = CLK_HZ / 1000 * WINDOW_MS;
  localparam int DW = $clog2(OSR_DIV + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(OSR_DIV - 1);
  localparam logic [TW-1:0] TMR_LAST = TW'(TIMEOUT_CYC - 1);

  typedef enum logic [1:0] {CHECK, LISTEN, FINISH} st_t;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_t;

  st_t st;
  rx_t rx_st;
  logic [DW-1:0] div;
  logic [TW-1:0] tmr;
  logic [3:0] cnt;
  logic [2:0] bitn;
  logic [7:0] shreg;
  logic s1, s2;

  wire vec_ok = (boot_vec >= VEC_LO) && (boot_vec <= VEC_HI);
  wire tick = (div == DIV_LAST);
  wire hit = (rx_st == RX_STOP) && tick && (cnt == 4'd15) && s2 && (shreg == SYNC_BYTE);

  assign rx_en = (st == LISTEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= CHECK;
      done <= 1'b0;
      boot_mode <= 1'b0;
      start_addr <= '0;
      div <= '0;
      tmr <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        CHECK: begin
          if (vec_ok) begin
            done <= 1'b1;
            start_addr <= boot_vec;
            st <= FINISH;
          end else if (rst_cause != INIT_CAUSE) begin
            done <= 1'b1;
            start_addr <= DEF_ENTRY;
            st <= FINISH;
          end else begin
            st <= LISTEN;
            div <= '0;
            tmr <= '0;
          end
        end
        LISTEN: begin
          div <= tick ? '0 : div + 1'b1;
          tmr <= tmr + 1'b1;
          if (hit) begin
            done <= 1'b1;
            boot_mode <= 1'b1;
            start_addr <= '0;
            st <= FINISH;
          end else if (tmr == TMR_LAST) begin
            done <= 1'b1;
            start_addr <= DEF_ENTRY;
            st <= FINISH;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st <= RX_IDLE;
      cnt <= '0;
      bitn <= '0;
      shreg <= '0;
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      if (st != LISTEN) begin
        rx_st <= RX_IDLE;
        cnt <= '0;
      end else if (tick) begin
        case (rx_st)
          RX_IDLE: if (!s2) begin
            rx_st <= RX_START;
            cnt <= '0;
          end
          RX_START: if (cnt == 4'd7) begin
            cnt <= '0;
            bitn <= '0;
            rx_st <= s2 ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + 1'b1;
          RX_DATA: if (cnt == 4'd15) begin
            cnt <= '0;
            shreg <= {s2, shreg[7:1]};
            if (bitn == 3'd7) rx_st <= RX_STOP;
            else bitn <= bitn + 1'b1;
          end else cnt <= cnt + 1'b1;
          RX_STOP: if (cnt == 4'd15) begin
            cnt <= '0;
            rx_st <= RX_IDLE;
          end else cnt <= cnt + 1'b1;
          default: rx_st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/boot_decider_props.sv
module boot_decider_props #(
  parameter int TIMEOUT = 100,
  parameter logic [31:0] VEC_LO = 32'h0004_0000,
  parameter logic [31:0] VEC_HI = 32'h0013_FFFF,
  parameter logic [31:0] DEF_ENTRY = 32'h000F_4000,
  parameter logic [7:0] INIT_CAUSE = 8'h80
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] boot_vec,
  input logic [7:0]  rst_cause,
  input logic        rx_en,
  input logic        done,
  input logic        boot_mode,
  input logic [31:0] start_addr
);
  logic fin;
  int open_cnt;
  wire in_rng = (boot_vec >= VEC_LO) && (boot_vec <= VEC_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin <= 1'b0;
      open_cnt <= 0;
    end else begin
      fin <= fin | done;
      open_cnt <= rx_en ? open_cnt + 1 : 0;
    end
  end

  assert_vector_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done && in_rng |-> !boot_mode && start_addr == boot_vec);
  assert_default_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done && !in_rng && rst_cause != INIT_CAUSE |-> !boot_mode && start_addr == DEF_ENTRY);
  assert_listen_only_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |-> rst_cause == INIT_CAUSE && !in_rng);
  assert_boot_from_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && boot_mode |-> $past(rx_en) && start_addr == 32'h0);
  assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    open_cnt <= TIMEOUT);
  assert_window_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rx_en);
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin && !done |-> $stable(start_addr) && $stable(boot_mode) && !rx_en);
endmodule

bind boot_decider boot_decider_props #(
  .TIMEOUT(TIMEOUT_CYC), .VEC_LO(VEC_LO), .VEC_HI(VEC_HI),
  .DEF_ENTRY(DEF_ENTRY), .INIT_CAUSE(INIT_CAUSE)
) u_props (
  .clk(clk), .rst_n(rst_n), .boot_vec(boot_vec), .rst_cause(rst_cause),
  .rx_en(rx_en), .done(done), .boot_mode(boot_mode), .start_addr(start_addr)
);

// File: tb/boot_decider_test.sv
module boot_decider_test;
  localparam int CLK_HZ = 153600;
  localparam int BAUD = 2400;
  localparam int WIN_MS = 100;
  localparam int DIV = CLK_HZ / (BAUD * 16);
  localparam int BITC = 16 * DIV;
  localparam int TMO = CLK_HZ / 1000 * WIN_MS;
  localparam logic [31:0] DEF = 32'h000F_4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] boot_vec = '0;
  logic [7:0] rst_cause = '0;
  logic rxd = 1'b1;
  logic rx_en, done, boot_mode;
  logic [31:0] start_addr;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  int fr_at[$];
  int fr_val[$];
  int fr_bad[$];
  int gl_at, gl_len;

  always #4 clk = ~clk;

  boot_decider #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .WINDOW_MS(WIN_MS)) uut (
    .clk(clk), .rst_n(rst_n), .boot_vec(boot_vec), .rst_cause(rst_cause),
    .rxd(rxd), .rx_en(rx_en), .done(done), .boot_mode(boot_mode),
    .start_addr(start_addr));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: run did not end");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic line_at(input int n);
    if (n >= gl_at && n < gl_at + gl_len) return 1'b0;
    foreach (fr_at[i]) begin
      if (n >= fr_at[i] && n < fr_at[i] + 10 * BITC) begin
        int idx = (n - fr_at[i]) / BITC;
        if (idx == 0) return 1'b0;
        if (idx == 9) return fr_bad[i] ? 1'b0 : 1'b1;
        return fr_val[i][idx-1];
      end
    end
    return 1'b1;
  endfunction

  // kind: 0 vector now, 1 default now, 2 timeout, 3 sync byte in [lo,hi]
  task automatic run_case(input string nm, input logic [31:0] vec, input logic [7:0] cause,
                          input int kind, input int lo, input int hi);
    int done_at = -1;
    logic [31:0] exp_addr;
    logic exp_mode;
    boot_vec = vec;
    rst_cause = cause;
    rxd = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({nm, " R8 reset done"}, {31'b0, done}, 32'd0);
    chk({nm, " R8 reset rx_en"}, {31'b0, rx_en}, 32'd0);
    chk({nm, " R8 reset addr"}, start_addr, 32'd0);
    chk({nm, " R8 reset mode"}, {31'b0, boot_mode}, 32'd0);
    rst_n = 1'b1;
    exp_mode = (kind == 3);
    exp_addr = (kind == 0) ? vec : (kind == 3) ? 32'h0 : DEF;
    for (int n = 1; n < TMO + 200; n++) begin
      @(negedge clk);
      if (done_at < 0) begin
        // R3: window open while listening, never in immediate cases
        chk({nm, " R3 rx_en"}, {31'b0, rx_en}, {31'b0, (kind >= 2) && !done});
        if (done) begin
          done_at = n;
          if (kind <= 1) chk({nm, " R1/R2 due edge"}, n, 1);
          else if (kind == 2) chk({nm, " R5 timeout edge"}, n, TMO + 1);
          else begin
            tests++;
            if (n < lo || n > hi) begin
              fails++;
              $display("FAIL %s R4: sync result at edge %0d expected %0d..%0d", nm, n, lo, hi);
            end
          end
          chk({nm, kind == 0 ? " R1 addr" : kind == 3 ? " R4 addr" : " R2/R5 addr"}, start_addr, exp_addr);
          chk({nm, kind == 3 ? " R4 mode" : " R1/R2/R5 mode"}, {31'b0, boot_mode}, {31'b0, exp_mode});
        end else if ((kind <= 1 && n >= 1) || (kind == 2 && n > TMO + 1) || (kind == 3 && n > hi)) begin
          tests++;
          fails++;
          $display("FAIL %s R6/R1/R5: no done by edge %0d, got 0 expected 1", nm, n);
          break;
        end
      end else begin
        chk({nm, " R8 single pulse"}, {31'b0, done}, 32'd0);
        chk({nm, " R8 held addr"}, start_addr, exp_addr);
        chk({nm, " R8 held mode"}, {31'b0, boot_mode}, {31'b0, exp_mode});
        chk({nm, " R5 window closed"}, {31'b0, rx_en}, 32'd0);
        if (n >= done_at + 40) break;
      end
      rxd = line_at(n);
    end
    fr_at.delete(); fr_val.delete(); fr_bad.delete();
    gl_at = -1000; gl_len = 0;
  endtask

  initial begin
    gl_at = -1000; gl_len = 0;
    // R1 range limits, vector wins even with init cause
    run_case("vec_low", 32'h0004_0000, 8'h80, 0, 0, 0);
    run_case("vec_high", 32'h0013_FFFF, 8'h01, 0, 0, 0);
    // R2 out of range, non-init causes
    run_case("below_range", 32'h0003_FFFF, 8'h01, 1, 0, 0);
    run_case("above_range", 32'h0014_0000, 8'h00, 1, 0, 0);
    run_case("erased_other", 32'hFFFF_FFFF, 8'h81, 1, 0, 0);
    // R5 silent window, R9 window length
    run_case("silent", 32'hFFFF_FFFF, 8'h80, 2, 0, 0);
    // R4 plain sync byte
    fr_at.push_back(100); fr_val.push_back(8'h56); fr_bad.push_back(0);
    run_case("sync", 32'hFFFF_FFFF, 8'h80, 3, 100 + 9 * BITC, 100 + 10 * BITC + 8);
    // R6 other byte first, then sync
    fr_at.push_back(100); fr_val.push_back(8'h55); fr_bad.push_back(0);
    fr_at.push_back(100 + 11 * BITC); fr_val.push_back(8'h56); fr_bad.push_back(0);
    run_case("other_then_sync", 32'h0000_0000, 8'h80, 3,
             100 + 20 * BITC, 100 + 21 * BITC + 8);
    // R6 bad stop bit: dropped, window times out
    fr_at.push_back(200); fr_val.push_back(8'h56); fr_bad.push_back(1);
    run_case("bad_stop", 32'hFFFF_FFFF, 8'h80, 2, 0, 0);
    // R7 short glitch rejected, later frame accepted
    gl_at = 100; gl_len = BITC / 2 - 12;
    fr_at.push_back(400); fr_val.push_back(8'h56); fr_bad.push_back(0);
    run_case("glitch_then_sync", 32'hFFFF_FFFF, 8'h80, 3, 400 + 9 * BITC, 400 + 10 * BITC + 8);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule